// File: doc/BRIEF.md
# Condition-Field to Integer Predicate Packer

This unit converts a run of 4-bit condition fields into integer predicate bits, one element per cycle. A single request starts it. For each element it fetches one condition field, compares the field bit by bit with a mode pattern under a select mask, and reduces the result to one bit. That bit either goes into successive bit positions of a single integer register, or into the least significant bit of successive packed elements of an integer register vector.

A request carries these operands:

- the element count (VL);
- the first condition-field index;
- the destination register index;
- two flags that choose vector or scalar addressing for the source and for the destination;
- the 4-bit select mask and the 4-bit mode pattern;
- the destination element width.

The unit reads condition fields through a port with one cycle of latency. It writes the register file through a write port with byte enables. The element width shapes only the integer side of the transfer. It has no effect on the condition fields.

Top module: `pred_pack`

## Requirements
- R1: The predicate bit of an element is 1 exactly when some bit k (0..3) has select mask bit k set and condition-field bit k equal to mode bit k.
- R2: An accepted request with effective length n > 0 issues exactly n condition-field reads, one per cycle. Read data is taken on the cycle after `cf_rd_en`.
- R3: With `op_src_vec` set, element i reads field (base + i) modulo the field count. With it clear, every element reads field base.
- R4: With `op_dst_vec` clear, the effective length is min(VL, element width in bits). The unit makes exactly one write, to register `op_dst`. That write has bit i equal to the predicate of element i, all bits at or above the effective length zero, and byte enables set on bytes 0 to (element bytes - 1).
- R5: With `op_dst_vec` set, element i is written on its own to register `op_dst` + i / p, where p = 8 / element bytes. The write goes to slot s = i mod p. Byte enables are set only on bytes s*eb to s*eb + eb - 1, where eb is the element byte count. The data holds the predicate at bit s*8*eb and zeros elsewhere. Width code `op_ew`: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits.
- R6: After reset, `busy`, `done`, `wr_en` and `cf_rd_en` are low. Once a request with n > 0 is accepted, `busy` is high from the next cycle. `done` is a one-cycle pulse, coincident with the last write, while `busy` is low. `done` is seen n + 2 clock edges after the accepting edge.
- R7: A request with effective length 0 issues no read and no write. It raises `done` in the cycle right after acceptance.
- R8: An all-zero select mask yields predicate 0 for every element, whatever the field contents.
- R9: `start` is ignored while `busy` is high. The operands are captured at acceptance, so a running request completes with its original operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted when not busy |
| busy | output | 1 | Element loop running |
| done | output | 1 | One-cycle completion pulse |
| op_vl | input | VLW | Element count |
| op_cf_base | input | CFW | First condition-field index |
| op_dst | input | RW | Destination register index |
| op_src_vec | input | 1 | Source fields advance per element |
| op_dst_vec | input | 1 | Destination is a packed element vector |
| op_mask | input | 4 | Select mask |
| op_mode | input | 4 | Mode pattern compared with the field |
| op_ew | input | 2 | Destination element width code |
| cf_rd_en | output | 1 | Condition-field read request |
| cf_rd_idx | output | CFW | Condition-field read index |
| cf_rd_data | input | 4 | Field data, one cycle after request |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | RW | Register write index |
| wr_data | output | XLEN | Register write data |
| wr_be | output | XLEN/8 | Register write byte enables |

## Verification
The bench drives all 256 mask and mode pairs with the field pattern reseeded on each run, and sweeps every combination of element width, source and destination addressing, and lengths. The lengths include 0, 1, a full element width, lengths above the width (a design that does not clamp would write stray bits above the element) and 64 (a design with a bad register-step or slot computation would put vector elements in the wrong register or bytes). Starting bases near the top of the field range catch index wrap errors, and an all-zero mask catches a reduction that ignores the select bits. A second start pulse mid-run catches a design that re-accepts, which would show up as an extra done pulse or corrupted results.

// File: rtl/pred_pack_pkg.sv
package pred_pack_pkg;

  localparam int unsigned CF_BITS = 4;

  typedef logic [CF_BITS-1:0] cf_t;

  typedef enum logic [1:0] {
    EW_B8  = 2'd0,
    EW_B16 = 2'd1,
    EW_B32 = 2'd2,
    EW_B64 = 2'd3
  } ew_e;

  function automatic int unsigned ew_bits(input logic [1:0] code);
    return 32'd8 << code;
  endfunction

endpackage

// File: rtl/pred_pack_seq.sv
module pred_pack_seq
  import pred_pack_pkg::*;
#(
  parameter int unsigned VLW = 7,
  parameter int unsigned CFW = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] op_vl,
  input  logic [CFW-1:0] op_cf_base,
  input  logic           op_src_vec,
  input  logic           op_dst_vec,
  input  logic [1:0]     op_ew,
  output logic           cf_rd_en,
  output logic [CFW-1:0] cf_rd_idx,
  output logic           run,
  output logic           accept,
  output logic           rsp_vld,
  output logic [VLW-1:0] rsp_idx,
  output logic           rsp_last,
  output logic           done,
  output logic           src_vec_q
);

  logic           run_q, run_d;
  logic [VLW-1:0] vl_q, vl_eff;
  logic [CFW-1:0] base_q;
  logic [VLW-1:0] cnt_q, cnt_d;
  logic           rsp_vld_q;
  logic [VLW-1:0] rsp_idx_q;
  logic           done_q, done_d;
  logic           issue;

  // effective length: scalar destination limited to element width
  always_comb begin
    vl_eff = op_vl;
    if (!op_dst_vec && (int'(op_vl) > int'(ew_bits(op_ew))))
      vl_eff = VLW'(ew_bits(op_ew));
  end

  assign accept   = start && !run_q;
  assign issue    = run_q && (cnt_q < vl_q);
  assign rsp_last = rsp_vld_q && (rsp_idx_q == (vl_q - 1'b1));

  always_comb begin
    run_d = run_q;
    if (accept && (vl_eff != '0))
      run_d = 1'b1;
    else if (rsp_last)
      run_d = 1'b0;

    cnt_d = cnt_q;
    if (accept)
      cnt_d = '0;
    else if (issue)
      cnt_d = cnt_q + 1'b1;

    done_d = (accept && (vl_eff == '0)) || rsp_last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q     <= 1'b0;
      cnt_q     <= '0;
      rsp_vld_q <= 1'b0;
      rsp_idx_q <= '0;
      done_q    <= 1'b0;
      vl_q      <= '0;
      base_q    <= '0;
      src_vec_q <= 1'b0;
    end else begin
      run_q     <= run_d;
      cnt_q     <= cnt_d;
      rsp_vld_q <= issue;
      done_q    <= done_d;
      if (issue)
        rsp_idx_q <= cnt_q;
      if (accept) begin
        vl_q      <= vl_eff;
        base_q    <= op_cf_base;
        src_vec_q <= op_src_vec;
      end
    end
  end

  assign cf_rd_en  = issue;
  assign cf_rd_idx = src_vec_q ? (base_q + CFW'(cnt_q)) : base_q;
  assign run       = run_q;
  assign rsp_vld   = rsp_vld_q;
  assign rsp_idx   = rsp_idx_q;
  assign done      = done_q;

endmodule

// File: rtl/pred_pack_reduce.sv
module pred_pack_reduce
  import pred_pack_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  cf_t  op_mask,
  input  cf_t  op_mode,
  input  cf_t  field,
  output logic pred,
  output cf_t  mask_q
);

  cf_t mode_q;
  cf_t term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      mode_q <= '0;
    end else if (accept) begin
      mask_q <= op_mask;
      mode_q <= op_mode;
    end
  end

  for (genvar k = 0; k < CF_BITS; k++) begin : g_term
    assign term[k] = mask_q[k] & ~(mode_q[k] ^ field[k]);
  end

  assign pred = |term;

endmodule

// File: rtl/pred_pack_wr.sv
module pred_pack_wr #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned VLW  = 7,
  parameter int unsigned RW   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [RW-1:0]     op_dst,
  input  logic              op_dst_vec,
  input  logic [1:0]        op_ew,
  input  logic              rsp_vld,
  input  logic [VLW-1:0]    rsp_idx,
  input  logic              rsp_last,
  input  logic              pred,
  output logic              wr_en,
  output logic [RW-1:0]     wr_idx,
  output logic [XLEN-1:0]   wr_data,
  output logic [XLEN/8-1:0] wr_be,
  output logic              dst_vec_q
);

  localparam int unsigned BYTES   = XLEN / 8;
  localparam int unsigned BYTE_LG = $clog2(BYTES);

  logic [XLEN-1:0]  acc_q, acc_d;
  logic [RW-1:0]    dst_q;
  logic [1:0]       ew_q;
  logic             wr_en_q, wr_en_d;
  logic [RW-1:0]    wr_idx_q, wr_idx_d;
  logic [XLEN-1:0]  wr_data_q, wr_data_d;
  logic [BYTES-1:0] wr_be_q, wr_be_d;
  int unsigned      lg_epr, slot, roff;

  always_comb begin
    lg_epr = BYTE_LG - 32'(ew_q);
    slot   = 32'(rsp_idx) & ((32'd1 << lg_epr) - 32'd1);
    roff   = 32'(rsp_idx) >> lg_epr;

    acc_d     = acc_q;
    wr_en_d   = 1'b0;
    wr_idx_d  = wr_idx_q;
    wr_data_d = wr_data_q;
    wr_be_d   = wr_be_q;

    if (accept) begin
      acc_d = '0;
    end else if (rsp_vld) begin
      acc_d = acc_q | (XLEN'(pred) << rsp_idx);
      if (dst_vec_q) begin
        wr_en_d   = 1'b1;
        wr_idx_d  = dst_q + RW'(roff);
        wr_data_d = XLEN'(pred) << (slot << (32'(ew_q) + 32'd3));
        for (int b = 0; b < int'(BYTES); b++)
          wr_be_d[b] = ((32'(b) >> ew_q) == slot);
      end else if (rsp_last) begin
        wr_en_d   = 1'b1;
        wr_idx_d  = dst_q;
        wr_data_d = acc_d;
        for (int b = 0; b < int'(BYTES); b++)
          wr_be_d[b] = (32'(b) < (32'd1 << ew_q));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      dst_q     <= '0;
      dst_vec_q <= 1'b0;
      ew_q      <= '0;
      wr_en_q   <= 1'b0;
      wr_idx_q  <= '0;
      wr_data_q <= '0;
      wr_be_q   <= '0;
    end else begin
      wr_en_q <= wr_en_d;
      if (accept || rsp_vld)
        acc_q <= acc_d;
      if (accept) begin
        dst_q     <= op_dst;
        dst_vec_q <= op_dst_vec;
        ew_q      <= op_ew;
      end
      if (wr_en_d) begin
        wr_idx_q  <= wr_idx_d;
        wr_data_q <= wr_data_d;
        wr_be_q   <= wr_be_d;
      end
    end
  end

  assign wr_en   = wr_en_q;
  assign wr_idx  = wr_idx_q;
  assign wr_data = wr_data_q;
  assign wr_be   = wr_be_q;

endmodule

// File: rtl/pred_pack.sv
module pred_pack
  import pred_pack_pkg::*;
#(
  parameter int unsigned XLEN = 64,
  parameter int unsigned VLW  = 7,
  parameter int unsigned CFW  = 6,
  parameter int unsigned RW   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  input  logic [VLW-1:0]    op_vl,
  input  logic [CFW-1:0]    op_cf_base,
  input  logic [RW-1:0]     op_dst,
  input  logic              op_src_vec,
  input  logic              op_dst_vec,
  input  logic [3:0]        op_mask,
  input  logic [3:0]        op_mode,
  input  logic [1:0]        op_ew,
  output logic              cf_rd_en,
  output logic [CFW-1:0]    cf_rd_idx,
  input  logic [3:0]        cf_rd_data,
  output logic              wr_en,
  output logic [RW-1:0]     wr_idx,
  output logic [XLEN-1:0]   wr_data,
  output logic [XLEN/8-1:0] wr_be
);

  logic [1:0]     rst_sync_q;
  logic           rst_int_n;
  logic           run, accept, rsp_vld, rsp_last, pred;
  logic [VLW-1:0] rsp_idx;
  logic           src_vec_q, dst_vec_q;
  cf_t            mask_q;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pred_pack_seq #(.VLW(VLW), .CFW(CFW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .start      (start),
    .op_vl      (op_vl),
    .op_cf_base (op_cf_base),
    .op_src_vec (op_src_vec),
    .op_dst_vec (op_dst_vec),
    .op_ew      (op_ew),
    .cf_rd_en   (cf_rd_en),
    .cf_rd_idx  (cf_rd_idx),
    .run        (run),
    .accept     (accept),
    .rsp_vld    (rsp_vld),
    .rsp_idx    (rsp_idx),
    .rsp_last   (rsp_last),
    .done       (done),
    .src_vec_q  (src_vec_q)
  );

  pred_pack_reduce u_reduce (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .accept  (accept),
    .op_mask (op_mask),
    .op_mode (op_mode),
    .field   (cf_rd_data),
    .pred    (pred),
    .mask_q  (mask_q)
  );

  pred_pack_wr #(.XLEN(XLEN), .VLW(VLW), .RW(RW)) u_wr (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .accept     (accept),
    .op_dst     (op_dst),
    .op_dst_vec (op_dst_vec),
    .op_ew      (op_ew),
    .rsp_vld    (rsp_vld),
    .rsp_idx    (rsp_idx),
    .rsp_last   (rsp_last),
    .pred       (pred),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .wr_be      (wr_be),
    .dst_vec_q  (dst_vec_q)
  );

  assign busy = run;

endmodule

// File: rtl/pred_pack_chk.sv
module pred_pack_chk #(
  parameter int unsigned XLEN = 64,
  parameter int unsigned VLW  = 7,
  parameter int unsigned CFW  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [VLW-1:0]    op_vl,
  input logic              cf_rd_en,
  input logic [CFW-1:0]    cf_rd_idx,
  input logic              wr_en,
  input logic [XLEN-1:0]   wr_data,
  input logic [XLEN/8-1:0] wr_be,
  input logic              src_vec_q,
  input logic              dst_vec_q,
  input logic [3:0]        mask_q
);

  // R6
  busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op_vl != '0) |=> busy);

  // R7
  zero_len_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && op_vl == '0) |=> (done && !busy && !wr_en));

  // R7
  idle_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cf_rd_en);

  // R3
  src_vec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_rd_en && $past(cf_rd_en) && src_vec_q) |-> (cf_rd_idx == CFW'($past(cf_rd_idx) + 1'b1)));

  // R3
  src_scalar_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_rd_en && $past(cf_rd_en) && !src_vec_q) |-> $stable(cf_rd_idx));

  // R5
  vec_single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && dst_vec_q) |-> ($countones(wr_data) <= 1));

  // R8
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mask_q == '0) |-> (wr_data == '0));

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R4
  write_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_be != '0));

endmodule

bind pred_pack pred_pack_chk #(.XLEN(XLEN), .VLW(VLW), .CFW(CFW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .op_vl     (op_vl),
  .cf_rd_en  (cf_rd_en),
  .cf_rd_idx (cf_rd_idx),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .wr_be     (wr_be),
  .src_vec_q (src_vec_q),
  .dst_vec_q (dst_vec_q),
  .mask_q    (mask_q)
);

// File: tb/pred_pack_bench.sv
`timescale 1ns/1ps
module pred_pack_bench;

  localparam int XLEN = 64;
  localparam int VLW  = 7;
  localparam int CFW  = 6;
  localparam int RW   = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              start;
  logic              busy, done;
  logic [VLW-1:0]    op_vl;
  logic [CFW-1:0]    op_cf_base;
  logic [RW-1:0]     op_dst;
  logic              op_src_vec, op_dst_vec;
  logic [3:0]        op_mask, op_mode;
  logic [1:0]        op_ew;
  logic              cf_rd_en;
  logic [CFW-1:0]    cf_rd_idx;
  logic [3:0]        cf_rd_data;
  logic              wr_en;
  logic [RW-1:0]     wr_idx;
  logic [XLEN-1:0]   wr_data;
  logic [XLEN/8-1:0] wr_be;

  always #5 clk = ~clk;

  pred_pack #(.XLEN(XLEN), .VLW(VLW), .CFW(CFW), .RW(RW)) u_pred_pack (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .op_vl(op_vl), .op_cf_base(op_cf_base), .op_dst(op_dst),
    .op_src_vec(op_src_vec), .op_dst_vec(op_dst_vec),
    .op_mask(op_mask), .op_mode(op_mode), .op_ew(op_ew),
    .cf_rd_en(cf_rd_en), .cf_rd_idx(cf_rd_idx), .cf_rd_data(cf_rd_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_be(wr_be)
  );

  logic [3:0]  cf_mem [64];
  logic [4:0]  wlog_idx [128];
  logic [63:0] wlog_data [128];
  logic [7:0]  wlog_be [128];
  logic [5:0]  rlog [128];
  int n_wr, n_rd, n_done, cyc, s_cyc, d_cyc;
  int n_chk, n_fail;
  bit finished;

  // field store with one cycle of read latency
  always @(posedge clk) if (cf_rd_en) cf_rd_data <= cf_mem[cf_rd_idx];

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst_n) begin
      if (wr_en && n_wr < 128) begin
        wlog_idx[n_wr] = wr_idx; wlog_data[n_wr] = wr_data; wlog_be[n_wr] = wr_be;
      end
      if (wr_en) n_wr = n_wr + 1;
      if (cf_rd_en && n_rd < 128) rlog[n_rd] = cf_rd_idx;
      if (cf_rd_en) n_rd = n_rd + 1;
      if (done) begin n_done = n_done + 1; d_cyc = cyc; end
      if (start && !busy) s_cyc = cyc;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic bit pbit(input int i, input int base, input bit sv, input logic [3:0] m, input logic [3:0] md);
    logic [3:0] f;
    f = cf_mem[(base + (sv ? i : 0)) & 63];
    return |(m & ~(md ^ f));
  endfunction

  task automatic run_op(input int vl, input int base, input int dst, input bit sv, input bit dv,
                        input logic [3:0] m, input logic [3:0] md, input int ew, input int seed, input bit poke);
    int n, wait_n, lg, slot, ebits;
    logic [63:0] exp_d;
    logic [7:0]  exp_be;
    bit ok;
    int bad;
    for (int k = 0; k < 64; k++) cf_mem[k] = 4'((k * 5 + seed + (k >> 3)) & 15);
    @(negedge clk);
    n_wr = 0; n_rd = 0; n_done = 0; s_cyc = 0; d_cyc = 0;
    op_vl = VLW'(vl); op_cf_base = CFW'(base); op_dst = RW'(dst);
    op_src_vec = sv; op_dst_vec = dv; op_mask = m; op_mode = md; op_ew = 2'(ew);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      op_vl = '0; op_mask = ~m; op_dst = RW'(dst + 3); op_src_vec = ~sv;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait_n = 0;
    while (n_done == 0 && wait_n < 300) begin @(negedge clk); wait_n++; end
    repeat (4) @(negedge clk);
    if (n_done == 0) chk(0, "R6 timeout", 0, 1);

    ebits = 8 << ew;
    n = (!dv && vl > ebits) ? ebits : vl;

    // R6 completion timing and single pulse
    chk(n_done == 1 && (d_cyc - s_cyc) == ((n == 0) ? 1 : n + 2), poke ? "R9 done" : "R6 latency",
        64'(d_cyc - s_cyc), 64'((n == 0) ? 1 : n + 2));

    // R2 R3 read count and indices
    bad = -1;
    for (int i = 0; i < n && i < 128; i++)
      if (rlog[i] != 6'((base + (sv ? i : 0)) & 63) && bad < 0) bad = i;
    chk(n_rd == n && bad < 0, "R2 R3 reads", 64'(n_rd), 64'(n));

    if (n == 0) begin
      chk(n_wr == 0, "R7 no write", 64'(n_wr), 0);
    end else if (!dv) begin
      exp_d = '0;
      for (int i = 0; i < n; i++) if (pbit(i, base, sv, m, md)) exp_d[i] = 1'b1;
      exp_be = (ew == 3) ? 8'hFF : 8'((1 << (1 << ew)) - 1);
      ok = (n_wr == 1) && wlog_idx[0] == 5'(dst) && wlog_be[0] == exp_be && wlog_data[0] == exp_d;
      chk(ok, (m == 0) ? "R8 scalar" : (poke ? "R9 scalar" : "R1 R4 scalar"), wlog_data[0], exp_d);
    end else begin
      lg = 3 - ew;
      bad = -1;
      exp_d = '0;
      for (int j = 0; j < n && j < 128; j++) begin
        slot   = j & ((1 << lg) - 1);
        exp_be = (ew == 3) ? 8'hFF : 8'(((1 << (1 << ew)) - 1) << (slot << ew));
        exp_d  = 64'(pbit(j, base, sv, m, md)) << (slot << (ew + 3));
        if (bad < 0 && (wlog_idx[j] != 5'((dst + (j >> lg)) & 31) ||
                        wlog_be[j] != exp_be || wlog_data[j] != exp_d)) bad = j;
      end
      chk(n_wr == n && bad < 0, (m == 0) ? "R8 vector" : "R1 R5 vector",
          (bad < 0) ? 64'(n_wr) : wlog_data[bad], (bad < 0) ? 64'(n) : exp_d);
    end
  endtask

  initial begin
    #1_900_000;
    chk(0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    int seed;
    int vls [6];
    logic [3:0] ms [3];
    logic [3:0] mds [3];
    vls = '{0, 1, 5, 8, 13, 64};
    ms  = '{4'hF, 4'h0, 4'h5};
    mds = '{4'h0, 4'h6, 4'hC};
    n_chk = 0; n_fail = 0; finished = 0; cyc = 0;
    n_wr = 0; n_rd = 0; n_done = 0;
    start = 0; op_vl = '0; op_cf_base = '0; op_dst = '0; op_src_vec = 0;
    op_dst_vec = 0; op_mask = '0; op_mode = '0; op_ew = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R6 reset state
    chk(!busy && !done && !wr_en && !cf_rd_en, "R6 reset", 64'({busy, done, wr_en, cf_rd_en}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !wr_en && !cf_rd_en, "R6 after reset", 64'({busy, done, wr_en, cf_rd_en}), 0);

    // R1 exhaustive mask and mode
    seed = 0;
    for (int m = 0; m < 16; m++)
      for (int md = 0; md < 16; md++) begin
        run_op(16, 3, 7, 1, 0, 4'(m), 4'(md), 1, seed, 0);
        seed++;
      end

    // configuration sweep
    for (int ew = 0; ew < 4; ew++)
      for (int dv = 0; dv < 2; dv++)
        for (int sv = 0; sv < 2; sv++)
          for (int v = 0; v < 6; v++)
            for (int p = 0; p < 3; p++) begin
              run_op(vls[v], (v & 1) ? 60 : 9, 29 + p, sv[0], dv[0], ms[p], mds[p], ew, seed, 0);
              seed++;
            end

    // R9 start while busy
    run_op(20, 11, 4, 1, 0, 4'h9, 4'h3, 2, 7, 1);
    run_op(20, 50, 2, 0, 1, 4'h6, 4'hA, 1, 9, 1);

    summary();
  end

endmodule